// File: doc/BRIEF.md
# Formatted Byte Stream Packetizer

This block accepts a byte-wide application stream in which every byte travels with a 3-bit format code. The code tells the block whether the byte is packet data, which packet type it belongs to (asynchronous or isochronous), and whether it is the final byte of the packet. Data bytes are packed big-endian into 32-bit quadlets. A final quadlet that is one to three bytes short is zero-padded. Each quadlet is written into an internal transmit queue together with first, last and type tags.

A packet only becomes visible to the link-side reader once its last quadlet is in the queue. On that cycle a commit strobe pulses. If the stream switches packet type before the last marker arrives, the block raises an error pulse and discards the partial packet. The block reports busy while the queue is full, and it ignores bytes offered while busy. A flush input empties the queue and the assembler at once.

The assembler is a three-state machine:
- `ST_IDLE`: no packet is open.
- `ST_ASYNC`: an asynchronous packet is open.
- `ST_ISO`: an isochronous packet is open.

Its transitions are:
- `ST_IDLE` → `ST_ASYNC` or `ST_ISO` on a non-final data byte of that type.
- `ST_IDLE` → `ST_IDLE` on a final byte, which forms a single-quadlet packet.
- `ST_ASYNC`/`ST_ISO` → same state on a matching non-final byte.
- `ST_ASYNC`/`ST_ISO` → `ST_IDLE` on a matching final byte (commit).
- `ST_ASYNC`/`ST_ISO` → `ST_IDLE` on a byte of the other type (error and discard).
- Any state → `ST_IDLE` on flush.

Top module: `fmt_byte_packetizer`

## Requirements
- R1: After reset, busy, q_valid, pkt_commit, fmt_err, almost_full and almost_empty are all 0.
- R2: Format code 3'b011 is a non-final asynchronous data byte and 3'b111 is the final asynchronous byte. Bytes are packed big-endian: the first byte of a quadlet lands in q_data[31:24] and the fourth in q_data[7:0].
- R3: Format code 3'b010 is a non-final isochronous data byte and 3'b110 is the final isochronous byte. q_iso is 1 for isochronous quadlets and 0 for asynchronous ones.
- R4: When the final byte of a packet falls at byte position 0, 1 or 2 of a quadlet, the remaining lower bytes of that quadlet read as zero.
- R5: q_first is 1 only on the first quadlet of a packet, and q_last is 1 only on its final quadlet; a single-quadlet packet carries both.
- R6: Quadlets of a packet are not readable (q_valid stays 0) until its final byte has been taken. pkt_commit pulses for one cycle in the cycle after the final byte is sampled, and q_valid is 1 in that same cycle.
- R7: busy is 1 while the queue holds QDEPTH quadlets; a byte offered while busy is ignored.
- R8: almost_full is 1 when exactly QDEPTH-1 quadlets are held, and almost_empty is 1 when exactly one quadlet is held; committed and uncommitted quadlets both count.
- R9: A flush cycle empties the queue and drops any partly assembled packet, so the next packet starts clean.
- R10: A data byte whose type differs from the open packet's type pulses fmt_err in the next cycle, discards every quadlet of the open packet, and is itself dropped.
- R11: Bytes with format codes 3'b000, 3'b001, 3'b100 or 3'b101 carry no data and are ignored.
- R12: One byte is accepted on every clock in which bd_wr is high and busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bd_byte | input | 8 | Application data byte |
| bd_fmt | input | 3 | Format code of the byte |
| bd_wr | input | 1 | Byte write strobe |
| flush | input | 1 | Empty queue and assembler |
| q_rd | input | 1 | Link pops the head quadlet |
| busy | output | 1 | Queue full, bytes ignored |
| q_valid | output | 1 | A committed quadlet is at the head |
| q_data | output | 32 | Head quadlet data |
| q_first | output | 1 | Head quadlet opens its packet |
| q_last | output | 1 | Head quadlet closes its packet |
| q_iso | output | 1 | Head quadlet is isochronous |
| pkt_commit | output | 1 | One-cycle strobe: packet released |
| fmt_err | output | 1 | One-cycle strobe: type change mid-packet |
| almost_full | output | 1 | One quadlet of space left |
| almost_empty | output | 1 | Exactly one quadlet held |

## Verification
A byte sampled on a rising edge can affect queue contents, the occupancy flags, busy, q_valid, pkt_commit and fmt_err no earlier than the following edge. The bench therefore drives each byte on a falling edge and reads these outputs on the next falling edge, one full cycle later. Head quadlets are combinational from the queue, so the monitor compares them on a falling edge and pops them with q_rd on the following rising edge. Expected quadlets are queued by the driver in send order and matched one by one as the monitor drains the design.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ASYNC = 2'd1,
        ST_ISO   = 2'd2
    } asm_state_t;

    // One queued quadlet with its tags.
    typedef struct packed {
        logic [31:0] data;
        logic        first;
        logic        last;
        logic        iso;
    } quad_t;

    // Format code fields: [2] final byte, [1] data byte, [0] asynchronous.
    function automatic logic fmt_is_data(input logic [2:0] f);
        return f[1];
    endfunction

    function automatic logic fmt_is_iso(input logic [2:0] f);
        return !f[0];
    endfunction

    function automatic logic fmt_is_last(input logic [2:0] f);
        return f[2];
    endfunction

endpackage

// File: rtl/fbp_assembler.sv
module fbp_assembler
    import fbp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  byte_i,
    input  logic [2:0]  fmt_i,
    input  logic        wr_i,
    input  logic        flush_i,
    input  logic        full_i,
    output logic        push_o,
    output quad_t       push_quad_o,
    output logic        commit_o,
    output logic        discard_o,
    output logic        pkt_done_o,
    output logic        fmt_err_o
);

    asm_state_t  state_q, state_d;
    logic [1:0]  idx_q;
    logic [31:0] acc_q;
    logic        first_q;
    logic        done_q, err_q;

    logic        accept, in_iso, is_last, mismatch;
    logic        ev_take, ev_err, quad_full;
    logic [31:0] merged;

    // Input decode
    always_comb begin
        accept   = wr_i && !full_i && !flush_i && fmt_is_data(fmt_i);
        in_iso   = fmt_is_iso(fmt_i);
        is_last  = fmt_is_last(fmt_i);
        mismatch = ((state_q == ST_ASYNC) && in_iso) ||
                   ((state_q == ST_ISO) && !in_iso);
        merged   = acc_q | ({byte_i, 24'h000000} >> {idx_q, 3'b000});
    end

    // Next state and events
    always_comb begin
        state_d = state_q;
        ev_take = 1'b0;
        ev_err  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    ev_take = 1'b1;
                    if (!is_last)
                        state_d = in_iso ? ST_ISO : ST_ASYNC;
                end
            end
            ST_ASYNC, ST_ISO: begin
                if (accept) begin
                    if (mismatch) begin
                        ev_err  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        ev_take = 1'b1;
                        if (is_last)
                            state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (flush_i)
            state_d = ST_IDLE;
    end

    // State register and assembly storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= 2'd0;
            acc_q   <= 32'h0;
            first_q <= 1'b1;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= ev_take && is_last;
            err_q   <= ev_err;
            if (flush_i || ev_err) begin
                idx_q   <= 2'd0;
                acc_q   <= 32'h0;
                first_q <= 1'b1;
            end else if (ev_take) begin
                if (quad_full) begin
                    idx_q   <= 2'd0;
                    acc_q   <= 32'h0;
                    first_q <= is_last;
                end else begin
                    idx_q   <= idx_q + 2'd1;
                    acc_q   <= merged;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        quad_full         = is_last || (idx_q == 2'd3);
        push_o            = ev_take && quad_full;
        push_quad_o.data  = merged;
        push_quad_o.first = first_q;
        push_quad_o.last  = is_last;
        push_quad_o.iso   = in_iso;
        commit_o          = ev_take && is_last;
        discard_o         = ev_err;
        pkt_done_o        = done_q;
        fmt_err_o         = err_q;
    end

    // R4: a final quadlet closed at position 0 carries zero padding
    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && push_quad_o.last && idx_q == 2'd0) |-> (push_quad_o.data[23:0] == 24'h0));

    // R7: nothing is pushed while the queue reports full
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full_i |-> !push_o);

    // R10: an error strobe never coincides with a commit strobe
    p_err_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |-> !pkt_done_o);

endmodule

// File: rtl/fbp_qfifo.sv
module fbp_qfifo
    import fbp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush_i,
    input  logic  push_i,
    input  quad_t push_quad_i,
    input  logic  commit_i,
    input  logic  discard_i,
    input  logic  rd_i,
    output logic  valid_o,
    output quad_t rd_quad_o,
    output logic  full_o,
    output logic  almost_full_o,
    output logic  almost_empty_o
);

    // DEPTH must be a power of two, at least 2.
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    quad_t         mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q, cmt_q;
    logic [PW-1:0] held;

    always_comb begin
        held           = wr_q - rd_q;
        full_o         = (held == PW'(DEPTH));
        almost_full_o  = (held == PW'(DEPTH - 1));
        almost_empty_o = (held == PW'(1));
        valid_o        = (cmt_q != rd_q);
        rd_quad_o      = mem[rd_q[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (push_i && !flush_i)
            mem[wr_q[AW-1:0]] <= push_quad_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cmt_q <= '0;
        end else begin
            if (discard_i)
                wr_q <= cmt_q;
            else if (push_i)
                wr_q <= wr_q + PW'(1);
            if (commit_i)
                cmt_q <= wr_q + PW'(1);
            if (rd_i && valid_o)
                rd_q <= rd_q + PW'(1);
        end
    end

    // R7: no write into a full queue
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R6: a commit makes the head readable next cycle
    p_commit_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !flush_i) |=> valid_o);

    // R6: readable region never runs past written region
    p_read_committed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_q - rd_q) <= (wr_q - rd_q));

    // R9: flush leaves the queue empty
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!valid_o && wr_q == rd_q));

endmodule

// File: rtl/fmt_byte_packetizer.sv
module fmt_byte_packetizer
    import fbp_pkg::*;
#(
    parameter int QDEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bd_byte,
    input  logic [2:0]  bd_fmt,
    input  logic        bd_wr,
    input  logic        flush,
    input  logic        q_rd,
    output logic        busy,
    output logic        q_valid,
    output logic [31:0] q_data,
    output logic        q_first,
    output logic        q_last,
    output logic        q_iso,
    output logic        pkt_commit,
    output logic        fmt_err,
    output logic        almost_full,
    output logic        almost_empty
);

    logic  push, commit, discard, full;
    quad_t push_quad, head_quad;

    fbp_assembler u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_i     (bd_byte),
        .fmt_i      (bd_fmt),
        .wr_i       (bd_wr),
        .flush_i    (flush),
        .full_i     (full),
        .push_o     (push),
        .push_quad_o(push_quad),
        .commit_o   (commit),
        .discard_o  (discard),
        .pkt_done_o (pkt_commit),
        .fmt_err_o  (fmt_err)
    );

    fbp_qfifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush),
        .push_i        (push),
        .push_quad_i   (push_quad),
        .commit_i      (commit),
        .discard_i     (discard),
        .rd_i          (q_rd),
        .valid_o       (q_valid),
        .rd_quad_o     (head_quad),
        .full_o        (full),
        .almost_full_o (almost_full),
        .almost_empty_o(almost_empty)
    );

    always_comb begin
        busy    = full;
        q_data  = head_quad.data;
        q_first = head_quad.first;
        q_last  = head_quad.last;
        q_iso   = head_quad.iso;
    end

    // R1: all strobes and flags clear right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !q_valid && !pkt_commit && !fmt_err));

endmodule

// File: tb/fmt_byte_packetizer_tb_top.sv
module fmt_byte_packetizer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH     = 8;
    localparam logic [2:0] F_ACONT = 3'b011;
    localparam logic [2:0] F_ALAST = 3'b111;
    localparam logic [2:0] F_ICONT = 3'b010;
    localparam logic [2:0] F_ILAST = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bd_byte = 8'h0;
    logic [2:0]  bd_fmt = 3'b000;
    logic        bd_wr = 1'b0;
    logic        flush = 1'b0;
    logic        q_rd = 1'b0;
    logic        busy, q_valid, q_first, q_last, q_iso;
    logic        pkt_commit, fmt_err, almost_full, almost_empty;
    logic [31:0] q_data;

    int          n_checks = 0;
    int          n_fail = 0;
    logic        rd_en = 1'b0;
    logic [34:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fmt_byte_packetizer #(.QDEPTH(QDEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bd_byte(bd_byte), .bd_fmt(bd_fmt),
        .bd_wr(bd_wr), .flush(flush), .q_rd(q_rd), .busy(busy),
        .q_valid(q_valid), .q_data(q_data), .q_first(q_first),
        .q_last(q_last), .q_iso(q_iso), .pkt_commit(pkt_commit),
        .fmt_err(fmt_err), .almost_full(almost_full),
        .almost_empty(almost_empty)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [34:0] act, input logic [34:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_q(input logic [31:0] d, input logic f, input logic l,
                            input logic iso, input string tag);
        exp_q.push_back({d, f, l, iso});
        tag_q.push_back(tag);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [2:0] f);
        @(negedge clk);
        bd_byte = b;
        bd_fmt  = f;
        bd_wr   = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        bd_wr  = 1'b0;
        bd_fmt = 3'b000;
    endtask

    task automatic set_rd(input logic v);
        @(posedge clk);
        #1 rd_en = v;
    endtask

    task automatic drain();
        for (int i = 0; i < 300 && exp_q.size() != 0; i++)
            @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    // Monitor: compares and pops the head quadlet.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en && q_valid) begin
                q_rd = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "unexpected quadlet R2", {q_data, q_first, q_last, q_iso}, 35'h0);
                end else begin
                    logic [34:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({q_data, q_first, q_last, q_iso} == e, t,
                        {q_data, q_first, q_last, q_iso}, e);
                end
            end else begin
                q_rd = 1'b0;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!busy && !q_valid && !pkt_commit && !fmt_err && !almost_full && !almost_empty,
            "R1 reset flags", {29'h0, busy, q_valid, pkt_commit, fmt_err, almost_full, almost_empty}, 35'h0);
        rst_n = 1'b1;
        set_rd(1'b1);

        // R2 R5 R6 eight-byte asynchronous packet
        for (int i = 0; i < 7; i++) send_byte(8'h11 + 8'(i), F_ACONT);
        idle();
        chk(!q_valid, "R6 not readable before final byte", {34'h0, q_valid}, 35'h0);
        chk(almost_empty, "R8 almost_empty with one uncommitted quadlet", {34'h0, almost_empty}, 35'h1);
        expect_q(32'h11121314, 1'b1, 1'b0, 1'b0, "R2 R5 async first quadlet");
        expect_q(32'h15161718, 1'b0, 1'b1, 1'b0, "R2 R5 async last quadlet");
        send_byte(8'h18, F_ALAST);
        idle();
        chk(pkt_commit && q_valid, "R6 commit strobe with q_valid", {33'h0, pkt_commit, q_valid}, 35'h3);
        @(negedge clk);
        chk(!pkt_commit, "R6 commit strobe is one cycle", {34'h0, pkt_commit}, 35'h0);
        drain();

        // R3 R4 isochronous packet, five bytes
        for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i), F_ICONT);
        send_byte(8'hA4, F_ILAST);
        expect_q(32'hA0A1A2A3, 1'b1, 1'b0, 1'b1, "R3 iso first quadlet");
        expect_q(32'hA4000000, 1'b0, 1'b1, 1'b1, "R4 iso pad three bytes");
        // R5 single-byte packet
        send_byte(8'h55, F_ILAST);
        expect_q(32'h55000000, 1'b1, 1'b1, 1'b1, "R5 single quadlet first and last");
        // R4 three-byte async packet
        send_byte(8'hC1, F_ACONT);
        send_byte(8'hC2, F_ACONT);
        send_byte(8'hC3, F_ALAST);
        expect_q(32'hC1C2C300, 1'b1, 1'b1, 1'b0, "R4 async pad one byte");
        idle();
        drain();

        // R11 non-data codes interleaved
        send_byte(8'h21, F_ACONT);
        send_byte(8'hEE, 3'b001);
        send_byte(8'h22, F_ACONT);
        send_byte(8'hEF, 3'b100);
        send_byte(8'h23, F_ACONT);
        send_byte(8'hED, 3'b000);
        send_byte(8'hEC, 3'b101);
        send_byte(8'h24, F_ALAST);
        expect_q(32'h21222324, 1'b1, 1'b1, 1'b0, "R11 non-data codes ignored");
        idle();
        drain();

        // R10 type change mid-packet
        for (int i = 0; i < 5; i++) send_byte(8'h31 + 8'(i), F_ACONT);
        send_byte(8'h36, F_ICONT);
        idle();
        chk(fmt_err, "R10 error strobe", {34'h0, fmt_err}, 35'h1);
        chk(!q_valid && !almost_empty, "R10 partial packet discarded",
            {33'h0, q_valid, almost_empty}, 35'h0);
        send_byte(8'h41, F_ILAST);
        expect_q(32'h41000000, 1'b1, 1'b1, 1'b1, "R10 clean packet after error");
        idle();
        drain();

        // R7 R8 fill the queue with reading halted
        set_rd(1'b0);
        for (int i = 0; i < 4 * (QDEPTH - 1); i++) send_byte(8'h80 + 8'(i), F_ACONT);
        idle();
        chk(almost_full && !busy, "R8 almost_full at depth minus one",
            {33'h0, almost_full, busy}, 35'h2);
        for (int i = 4 * (QDEPTH - 1); i < 4 * QDEPTH - 1; i++) send_byte(8'h80 + 8'(i), F_ACONT);
        send_byte(8'h80 + 8'(4 * QDEPTH - 1), F_ALAST);
        idle();
        chk(busy && q_valid && !almost_full, "R7 busy when full",
            {32'h0, busy, q_valid, almost_full}, 35'h6);
        send_byte(8'h99, F_ALAST);
        idle();
        chk(!pkt_commit && busy, "R7 byte ignored while busy", {33'h0, pkt_commit, busy}, 35'h1);
        for (int i = 0; i < QDEPTH; i++) begin
            logic [7:0] b0;
            b0 = 8'h80 + 8'(4 * i);
            expect_q({b0, b0 + 8'd1, b0 + 8'd2, b0 + 8'd3}, (i == 0), (i == QDEPTH - 1),
                     1'b0, "R7 R12 full-queue packet");
        end
        set_rd(1'b1);
        drain();
        chk(!q_valid && !busy, "R7 ignored byte never queued", {33'h0, q_valid, busy}, 35'h0);

        // R8 almost_empty with one committed quadlet
        set_rd(1'b0);
        send_byte(8'h77, F_ALAST);
        idle();
        chk(almost_empty && q_valid, "R8 almost_empty one held", {33'h0, almost_empty, q_valid}, 35'h3);
        expect_q(32'h77000000, 1'b1, 1'b1, 1'b0, "R8 single held quadlet");
        set_rd(1'b1);
        drain();

        // R9 flush drops committed and partial packets
        set_rd(1'b0);
        for (int i = 0; i < 3; i++) send_byte(8'h51 + 8'(i), F_ACONT);
        send_byte(8'h54, F_ALAST);
        send_byte(8'h56, F_ACONT);
        send_byte(8'h57, F_ACONT);
        idle();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(!q_valid && !almost_empty && !busy, "R9 queue empty after flush",
            {32'h0, q_valid, almost_empty, busy}, 35'h0);
        set_rd(1'b1);
        send_byte(8'h61, F_ALAST);
        expect_q(32'h61000000, 1'b1, 1'b1, 1'b0, "R9 partial bytes dropped by flush");
        idle();
        drain();

        // R12 back-to-back bytes, one per clock
        for (int i = 0; i < 11; i++) send_byte(8'hD0 + 8'(i), F_ICONT);
        send_byte(8'hDB, F_ILAST);
        expect_q(32'hD0D1D2D3, 1'b1, 1'b0, 1'b1, "R12 burst quadlet 0");
        expect_q(32'hD4D5D6D7, 1'b0, 1'b0, 1'b1, "R12 burst quadlet 1");
        expect_q(32'hD8D9DADB, 1'b0, 1'b1, 1'b1, "R12 burst quadlet 2");
        idle();
        drain();

        chk(exp_q.size() == 0, "R2 scoreboard drained", 35'(exp_q.size()), 35'h0);
        chk(!q_valid, "R6 nothing left readable", {34'h0, q_valid}, 35'h0);
        summary();
        $finish;
    end

endmodule